// File: doc/BRIEF.md
# Integer Execute Unit with Overflow Trap

This block is the integer arithmetic and logic stage of a small load/store core. Each cycle it may accept one operation with two register operands, a 16-bit immediate and a 5-bit constant shift count. One clock edge later it presents a 32-bit result. Alongside the result it gives a destination-write enable and a flag that requests an integer-overflow exception.

The block covers several operation families. Add and subtract come in two forms: one traps on signed overflow and one wraps silently. There are also bitwise logic with register or immediate operands, signed and unsigned less-than tests, constant and register-controlled shifts, loading a constant into the upper half of a word, and moves that depend on whether the second operand is zero. Each operation that uses the immediate extends it in its own way. Two conditions cancel the register write: a trapping overflow, and a conditional move whose test fails. Decoding, the register file and the exception handler live outside this block.

Top module: `int_exec_unit`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `valid_o`, `wr_en_o`, `ovf_o` and `result_o` are all zero. Every output reflects the inputs sampled at the previous rising clock edge, so the latency is one cycle.
- R2: Three trapping operations check for 32-bit two's-complement overflow: add register (code 0), add immediate (code 2) and subtract register (code 4). On overflow they set `ovf_o`=1 and `wr_en_o`=0. Without overflow they set `ovf_o`=0 and `wr_en_o`=1, and the result is the 32-bit sum or difference.
- R3: Three wrapping operations always write the low 32 bits of the result with `ovf_o`=0: add register (code 1), add immediate (code 3) and subtract register (code 5).
- R4: The add-immediate operations (codes 2, 3) and the signed and unsigned less-than-immediate operations (codes 15, 16) sign-extend `imm_i` from bit 15. The immediate AND, OR and XOR operations (codes 10, 11, 12) zero-extend it.
- R5: The bitwise operations act on `src_a_i` and the second operand and always write. With a register operand they are AND, OR, NOR and XOR (codes 6, 7, 8, 9). With the zero-extended immediate they are AND, OR and XOR (codes 10, 11, 12).
- R6: The less-than operations return 1 when `src_a_i` is less than the second operand and 0 otherwise. There are four: signed register (code 13), unsigned register (code 14), signed immediate (code 15) and unsigned immediate (code 16). The unsigned immediate form compares the sign-extended immediate as an unsigned 32-bit value. None of them ever sets `ovf_o`.
- R7: All shifts act on `src_b_i`. Codes 17, 18 and 19 shift by `shamt_i`: left, logical right and arithmetic right. Codes 20, 21 and 22 perform the same three shifts, using only `src_a_i[4:0]` as the count. An arithmetic right shift fills with bit 31, and the other shifts fill with zeros.
- R8: Upper-constant load (code 23) returns `{imm_i, 16'h0000}` and writes.
- R9: Move-if-zero (code 24) returns `src_a_i` and writes only when `src_b_i` is zero. Move-if-nonzero (code 25) returns `src_a_i` and writes only when `src_b_i` is non-zero.
- R10: Codes 26 to 31 give `wr_en_o`=0, `ovf_o`=0 and `result_o`=0. When `valid_i` is low, the next cycle has `valid_o`=0, `wr_en_o`=0 and `ovf_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | An operation is presented this cycle |
| op_i | input | 5 | Operation code (see requirements) |
| src_a_i | input | 32 | First register operand |
| src_b_i | input | 32 | Second register operand; shift source and move test value |
| imm_i | input | 16 | Immediate field |
| shamt_i | input | 5 | Constant shift count |
| valid_o | output | 1 | Result belongs to an accepted operation |
| result_o | output | 32 | Computed value |
| wr_en_o | output | 1 | Destination register is to be written |
| ovf_o | output | 1 | Integer-overflow exception request |

## Verification
All results, the write enable and the overflow flag pass through a single output register. Each of them is therefore due exactly one rising edge after the operation is presented. The bench drives each operation on a falling edge and compares all four outputs at the next falling edge, half a period after the register loads. It never samples earlier, and it never lets a second operation overwrite the result before that comparison. The sweep covers every operation code against a grid of corner operands and several immediates and shift counts. It also includes cycles with `valid_i` low, where the write and overflow outputs must fall back to zero on that same one-cycle schedule.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD_TRAP    = 5'd0,
        OP_ADD_WRAP    = 5'd1,
        OP_ADDI_TRAP   = 5'd2,
        OP_ADDI_WRAP   = 5'd3,
        OP_SUB_TRAP    = 5'd4,
        OP_SUB_WRAP    = 5'd5,
        OP_AND_R       = 5'd6,
        OP_OR_R        = 5'd7,
        OP_NOR_R       = 5'd8,
        OP_XOR_R       = 5'd9,
        OP_AND_I       = 5'd10,
        OP_OR_I        = 5'd11,
        OP_XOR_I       = 5'd12,
        OP_LT_S        = 5'd13,
        OP_LT_U        = 5'd14,
        OP_LT_SI       = 5'd15,
        OP_LT_UI       = 5'd16,
        OP_SHL_K       = 5'd17,
        OP_SHR_K       = 5'd18,
        OP_SHA_K       = 5'd19,
        OP_SHL_V       = 5'd20,
        OP_SHR_V       = 5'd21,
        OP_SHA_V       = 5'd22,
        OP_UPPER       = 5'd23,
        OP_MOVE_ZERO   = 5'd24,
        OP_MOVE_NZERO  = 5'd25
    } op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_NOR = 2'd2,
        LG_XOR = 2'd3
    } logic_sel_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RLOG  = 2'd1,
        SH_RARI  = 2'd2
    } shift_sel_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         ovf_o,
    output logic         lt_s_o,
    output logic         lt_u_o
);
    logic [W-1:0] b_eff;
    logic [W:0]   full;

    assign b_eff = sub_i ? ~b_i : b_i;
    assign full  = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
    assign sum_o = full[W-1:0];

    // Signed overflow: operands (after inversion for subtract) agree in sign,
    // result disagrees with them.
    assign ovf_o  = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);

    // Valid only with sub_i set: no carry out means a borrow, a < b unsigned.
    assign lt_u_o = ~full[W];
    assign lt_s_o = (a_i[W-1] != b_i[W-1]) ? a_i[W-1] : sum_o[W-1];
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import int_exec_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic_sel_e   sel_i,
    output logic [W-1:0] out_o
);
    always_comb begin
        unique case (sel_i)
            LG_AND:  out_o = a_i & b_i;
            LG_OR:   out_o = a_i | b_i;
            LG_NOR:  out_o = ~(a_i | b_i);
            default: out_o = a_i ^ b_i;
        endcase
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
    import int_exec_pkg::*;
#(
    parameter int W    = 32,
    parameter int SH_W = $clog2(W)
) (
    input  logic [W-1:0]    val_i,
    input  logic [SH_W-1:0] amt_i,
    input  shift_sel_e      sel_i,
    output logic [W-1:0]    out_o
);
    always_comb begin
        unique case (sel_i)
            SH_LEFT: out_o = val_i << amt_i;
            SH_RARI: out_o = $unsigned($signed(val_i) >>> amt_i);
            default: out_o = val_i >> amt_i;
        endcase
    end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import int_exec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] src_a_i,
    input  logic [DATA_W-1:0] src_b_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [$clog2(DATA_W)-1:0] shamt_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_en_o,
    output logic              ovf_o
);
    localparam int SH_W  = $clog2(DATA_W);
    localparam int EXT_W = DATA_W - IMM_W;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] result;
        logic              wr;
        logic              ovf;
    } out_t;

    out_t out_d, out_q;
    op_e  op;

    logic [DATA_W-1:0] imm_sx, imm_zx, imm_up;
    logic [DATA_W-1:0] add_b, logic_b, sum, logic_out, shift_out;
    logic              add_sub, add_ovf, lt_s, lt_u;
    logic_sel_e        lg_sel;
    shift_sel_e        sh_sel;
    logic [SH_W-1:0]   sh_amt;

    assign op     = op_e'(op_i);
    assign imm_sx = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    assign imm_zx = {{EXT_W{1'b0}}, imm_i};
    assign imm_up = {imm_i, {EXT_W{1'b0}}};

    // Operand steering for the shared datapath units.
    always_comb begin
        add_b   = src_b_i;
        add_sub = 1'b0;
        logic_b = src_b_i;
        lg_sel  = LG_AND;
        sh_sel  = SH_LEFT;
        sh_amt  = shamt_i;
        unique case (op)
            OP_ADDI_TRAP, OP_ADDI_WRAP: add_b = imm_sx;
            OP_SUB_TRAP, OP_SUB_WRAP, OP_LT_S, OP_LT_U: add_sub = 1'b1;
            OP_LT_SI, OP_LT_UI: begin
                add_b   = imm_sx;
                add_sub = 1'b1;
            end
            OP_OR_R:  lg_sel = LG_OR;
            OP_NOR_R: lg_sel = LG_NOR;
            OP_XOR_R: lg_sel = LG_XOR;
            OP_AND_I: logic_b = imm_zx;
            OP_OR_I: begin
                logic_b = imm_zx;
                lg_sel  = LG_OR;
            end
            OP_XOR_I: begin
                logic_b = imm_zx;
                lg_sel  = LG_XOR;
            end
            OP_SHR_K: sh_sel = SH_RLOG;
            OP_SHA_K: sh_sel = SH_RARI;
            OP_SHL_V: sh_amt = src_a_i[SH_W-1:0];
            OP_SHR_V: begin
                sh_sel = SH_RLOG;
                sh_amt = src_a_i[SH_W-1:0];
            end
            OP_SHA_V: begin
                sh_sel = SH_RARI;
                sh_amt = src_a_i[SH_W-1:0];
            end
            default: ;
        endcase
    end

    alu_addsub #(.W(DATA_W)) u_addsub (
        .a_i    (src_a_i),
        .b_i    (add_b),
        .sub_i  (add_sub),
        .sum_o  (sum),
        .ovf_o  (add_ovf),
        .lt_s_o (lt_s),
        .lt_u_o (lt_u)
    );

    alu_logic #(.W(DATA_W)) u_logic (
        .a_i   (src_a_i),
        .b_i   (logic_b),
        .sel_i (lg_sel),
        .out_o (logic_out)
    );

    alu_shift #(.W(DATA_W), .SH_W(SH_W)) u_shift (
        .val_i (src_b_i),
        .amt_i (sh_amt),
        .sel_i (sh_sel),
        .out_o (shift_out)
    );

    // Next-state computation.
    always_comb begin
        out_d        = '0;
        out_d.valid  = valid_i;
        unique case (op)
            OP_ADD_TRAP, OP_ADDI_TRAP, OP_SUB_TRAP: begin
                out_d.result = sum;
                out_d.ovf    = add_ovf;
                out_d.wr     = ~add_ovf;
            end
            OP_ADD_WRAP, OP_ADDI_WRAP, OP_SUB_WRAP: begin
                out_d.result = sum;
                out_d.wr     = 1'b1;
            end
            OP_AND_R, OP_OR_R, OP_NOR_R, OP_XOR_R,
            OP_AND_I, OP_OR_I, OP_XOR_I: begin
                out_d.result = logic_out;
                out_d.wr     = 1'b1;
            end
            OP_LT_S, OP_LT_SI: begin
                out_d.result = {{(DATA_W-1){1'b0}}, lt_s};
                out_d.wr     = 1'b1;
            end
            OP_LT_U, OP_LT_UI: begin
                out_d.result = {{(DATA_W-1){1'b0}}, lt_u};
                out_d.wr     = 1'b1;
            end
            OP_SHL_K, OP_SHR_K, OP_SHA_K,
            OP_SHL_V, OP_SHR_V, OP_SHA_V: begin
                out_d.result = shift_out;
                out_d.wr     = 1'b1;
            end
            OP_UPPER: begin
                out_d.result = imm_up;
                out_d.wr     = 1'b1;
            end
            OP_MOVE_ZERO: begin
                out_d.result = src_a_i;
                out_d.wr     = (src_b_i == '0);
            end
            OP_MOVE_NZERO: begin
                out_d.result = src_a_i;
                out_d.wr     = (src_b_i != '0);
            end
            default: ;
        endcase
        if (!valid_i) begin
            out_d.wr  = 1'b0;
            out_d.ovf = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign valid_o  = out_q.valid;
    assign result_o = out_q.result;
    assign wr_en_o  = out_q.wr;
    assign ovf_o    = out_q.ovf;

    AST_TRAP_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> !wr_en_o); // R2

    AST_WRAP_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (op == OP_ADD_WRAP || op == OP_ADDI_WRAP || op == OP_SUB_WRAP))
        |=> (wr_en_o && !ovf_o)); // R3

    AST_COMPARE_BOOLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (op == OP_LT_S || op == OP_LT_U || op == OP_LT_SI || op == OP_LT_UI))
        |=> (!ovf_o && result_o[DATA_W-1:1] == '0)); // R6

    AST_UPPER_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op == OP_UPPER) |=> (result_o[EXT_W-1:0] == '0)); // R8

    AST_MOVE_ZERO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op == OP_MOVE_ZERO && src_b_i != '0) |=> !wr_en_o); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!valid_o && !wr_en_o && !ovf_o)); // R10

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && !wr_en_o && !ovf_o && result_o == '0)); // R1
endmodule

// File: tb/int_exec_unit_bench.sv
module int_exec_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [4:0]  op_i = '0;
    logic [31:0] src_a_i = '0;
    logic [31:0] src_b_i = '0;
    logic [15:0] imm_i = '0;
    logic [4:0]  shamt_i = '0;
    logic        valid_o;
    logic [31:0] result_o;
    logic        wr_en_o;
    logic        ovf_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    int_exec_unit u_int_exec_unit (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .src_a_i(src_a_i), .src_b_i(src_b_i), .imm_i(imm_i), .shamt_i(shamt_i),
        .valid_o(valid_o), .result_o(result_o), .wr_en_o(wr_en_o), .ovf_o(ovf_o)
    );

    function automatic string tag_of(input int op);
        if (op == 0 || op == 2 || op == 4) return "R2";
        if (op == 1 || op == 3 || op == 5) return "R3";
        if (op >= 6 && op <= 9) return "R5";
        if (op >= 10 && op <= 12) return "R4";
        if (op >= 13 && op <= 16) return "R6";
        if (op >= 17 && op <= 22) return "R7";
        if (op == 23) return "R8";
        if (op == 24 || op == 25) return "R9";
        return "R10";
    endfunction

    task automatic model(input int op, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] imm, input logic [4:0] sh,
                         output logic [31:0] res, output logic wr, output logic ovf);
        longint sa, sb, si, wide;
        logic [31:0] sx, zx;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        si = longint'($signed(imm));
        sx = 32'(si);
        zx = {16'h0, imm};
        res = '0; wr = 1'b1; ovf = 1'b0;
        case (op)
            0, 1, 2, 3, 4, 5: begin
                if (op < 2)      wide = sa + sb;
                else if (op < 4) wide = sa + si;
                else             wide = sa - sb;
                res = 32'(wide);
                if (op == 0 || op == 2 || op == 4) begin
                    if (wide > 64'sd2147483647 || wide < -64'sd2147483648) begin
                        ovf = 1'b1; wr = 1'b0;
                    end
                end
            end
            6:  res = a & b;
            7:  res = a | b;
            8:  res = ~(a | b);
            9:  res = a ^ b;
            10: res = a & zx;
            11: res = a | zx;
            12: res = a ^ zx;
            13: res = (sa < sb) ? 32'd1 : 32'd0;
            14: res = (a < b) ? 32'd1 : 32'd0;
            15: res = (sa < si) ? 32'd1 : 32'd0;
            16: res = (a < sx) ? 32'd1 : 32'd0;
            17: res = a * 0 + (b << sh);
            18: res = b >> sh;
            19: res = 32'(sb >>> sh);
            20: res = b << a[4:0];
            21: res = b >> a[4:0];
            22: res = 32'(sb >>> a[4:0]);
            23: res = {imm, 16'h0};
            24: begin res = a; wr = (b == 0); end
            25: begin res = a; wr = (b != 0); end
            default: begin res = '0; wr = 1'b0; end
        endcase
    endtask

    task automatic check(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    logic [31:0] vals [8] = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000,
                              32'hFFFF_FFFF, 32'h1234_5678, 32'hFFFF_8000, 32'h0000_0021};
    logic [15:0] imms [4] = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFFFF};

    initial begin
        logic [31:0] er;
        logic ew, eo;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "valid", {31'h0, valid_o}, 32'h0);
        check("R1", "wr_en", {31'h0, wr_en_o}, 32'h0);
        check("R1", "ovf", {31'h0, ovf_o}, 32'h0);
        check("R1", "result", result_o, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "first cycle valid", {31'h0, valid_o}, 32'h0);

        for (int op = 0; op < 32; op++) begin
            for (int ia = 0; ia < 8; ia++) begin
                for (int ib = 0; ib < 8; ib++) begin
                    for (int ii = 0; ii < 4; ii++) begin
                        valid_i = 1'b1;
                        op_i    = 5'(op);
                        src_a_i = vals[ia] + 32'(ii * 3);
                        src_b_i = vals[ib];
                        imm_i   = imms[ii] ^ 16'(ia);
                        shamt_i = 5'(ia * 5 + ib * 3 + ii);
                        model(op, src_a_i, src_b_i, imm_i, shamt_i, er, ew, eo);
                        @(negedge clk);
                        check(tag_of(op), "valid", {31'h0, valid_o}, 32'h1);
                        check(tag_of(op), "result", result_o, er);
                        check(tag_of(op), "wr_en", {31'h0, wr_en_o}, {31'h0, ew});
                        check(tag_of(op), "ovf", {31'h0, ovf_o}, {31'h0, eo});
                    end
                end
            end
            // R10: idle cycle after each operation group must not write or trap
            valid_i = 1'b0;
            op_i    = 5'd0;
            src_a_i = 32'h7FFF_FFFF;
            src_b_i = 32'h0000_0001;
            @(negedge clk);
            check("R10", "idle valid", {31'h0, valid_o}, 32'h0);
            check("R10", "idle wr_en", {31'h0, wr_en_o}, 32'h0);
            check("R10", "idle ovf", {31'h0, ovf_o}, 32'h0);
        end

        // R2: directed overflow corners
        valid_i = 1'b1; op_i = 5'd4; src_a_i = 32'h8000_0000; src_b_i = 32'h1;
        @(negedge clk);
        check("R2", "sub min-1 ovf", {31'h0, ovf_o}, 32'h1);
        check("R2", "sub min-1 wr", {31'h0, wr_en_o}, 32'h0);
        op_i = 5'd2; src_a_i = 32'h7FFF_FFFF; imm_i = 16'hFFFF;
        @(negedge clk);
        check("R2", "addi max-1 result", result_o, 32'h7FFF_FFFE);
        check("R2", "addi max-1 ovf", {31'h0, ovf_o}, 32'h0);
        valid_i = 1'b0;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule